// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This core holds the time of day and the calendar date as eight packed-BCD bytes: hundredths of a second, seconds, minutes, hours, day of week, date, month and year. A single-cycle strobe at 100 Hz moves the count forward by one hundredth. Carries ripple upward through the whole chain in the same clock edge. The hours byte can count in a 24-hour form or in a 12-hour form with an afternoon flag. The length of each month follows from the month and the year, and leap years are included.

The core has no serial logic of its own. A separate access front end sees all eight bytes at once on a 64-bit read vector. It can replace all eight in one clock edge through a 64-bit load vector. The day-of-week byte also holds two control bits. One stops the count. The other is a reset-ignore flag that the core only stores and drives back out to the front end.

Top module: `bcd_calendar_core`

## Requirements
- R1: Reset (rst_n low at a clock edge) sets the read vector to 64'h00_01_01_31_00_00_00_00: year 00, month 01, date 01, day byte 8'h31, and hours, minutes, seconds and hundredths at 00. rst_ignore is 1.
- R2: A cycle with load_en high replaces all eight bytes on that edge. Byte k sits at bits 8k+7:8k, in this order: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. Bits outside the masks FF, 7F, 7F, BF, 37, 3F, 1F, FF (byte 0 to 7) are stored as 0 and read as 0.
- R3: A tick with counting enabled adds one hundredth in BCD (09 becomes 10). A tick in the same cycle as a load is discarded, and the loaded bytes appear unchanged.
- R4: Hundredths wrap from 99 to 00 and carry into seconds. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R5: When hours bit 7 is 0 (24-hour form), hours count 00 to 23. Bit 5 is the tens-of-hours bit for 20 to 23. A step past 23 gives 00 and advances day of week and date.
- R6: When hours bit 7 is 1 (12-hour form), bits 4:0 run 12, 01, 02 … 11. Bit 5 is the PM flag, with 1 meaning PM. The flag toggles on the step from 11 to 12. Only the step from PM 11 to AM 12 advances day of week and date.
- R7: Day of week (day byte bits 2:0) counts 1 to 7 and then wraps to 1.
- R8: Date wraps to 01 after 30 in months 04, 06, 09 and 11. In February it wraps after 29 when the BCD year is divisible by 4, 00 included, and after 28 otherwise. In all other months it wraps after 31. Each wrap advances the month.
- R9: Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00.
- R10: While day bit 5 is 1 the oscillator is off: ticks have no effect and every byte holds its value.
- R11: rst_ignore always equals day bit 4. That bit has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100hz | input | 1 | One-cycle strobe, one per hundredth of a second |
| load_en | input | 1 | Replace all eight bytes from load_data on this edge |
| load_data | input | 64 | New byte values, byte k at bits 8k+7:8k |
| rd_data | output | 64 | Present byte values, byte k at bits 8k+7:8k |
| rst_ignore | output | 1 | Stored reset-ignore control bit, for the front end |

## Verification
The range assertions on hours, and the wrap behaviour of each counter, assume that every load carries legal BCD for its field. This means a date no larger than the month's length, a 12-hour value from 01 to 12, and a 24-hour value no larger than 23. The bench only loads such values, and it puts ones in the unused bit positions only to test the masking. Ticks are single-cycle strobes, and the bench drives them in the same cycle as a load only to test that the load wins. Each roll-over test loads a value one hundredth before the boundary, so that one tick crosses it.

// File: rtl/cal_pkg.sv
// Package: shared sizes, field masks and BCD helper functions for the
// calendar core. Assumes packed BCD with a tens digit in the upper nibble.
package cal_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 8;
    localparam int VEC_W    = REG_W * NUM_REGS;

    // Byte indices; the front end depends on this order.
    localparam int IDX_HUND  = 0;
    localparam int IDX_SEC   = 1;
    localparam int IDX_MIN   = 2;
    localparam int IDX_HOUR  = 3;
    localparam int IDX_DAY   = 4;
    localparam int IDX_DATE  = 5;
    localparam int IDX_MONTH = 6;
    localparam int IDX_YEAR  = 7;

    // Bits that may hold a one; the others read 0.
    localparam logic [VEC_W-1:0] FIELD_MASK = 64'hFF_1F_3F_37_BF_7F_7F_FF;

    // Day byte control bit positions.
    localparam int DAY_OSC_OFF_BIT = 5;
    localparam int DAY_RST_IGN_BIT = 4;
    localparam logic [REG_W-1:0] DAY_COUNT_MASK = 8'h07;

    // Value after reset.
    localparam logic [VEC_W-1:0] RESET_VEC = 64'h00_01_01_31_00_00_00_00;

    // Add one to a two-digit BCD byte.
    function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] r;
        if (v[3:0] >= 4'h9) r = {v[7:4] + 4'h1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'h1};
        return r;
    endfunction

    // True when a BCD year 00..99 is a multiple of four.
    function automatic logic bcd_leap(input logic [REG_W-1:0] yr);
        logic l;
        if (yr[4] == 1'b0) l = (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
        else               l = (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
        return l;
    endfunction

    // Last date of a month, in BCD.
    function automatic logic [REG_W-1:0] bcd_month_len(input logic [REG_W-1:0] mo,
                                                      input logic [REG_W-1:0] yr);
        logic [REG_W-1:0] d;
        case (mo)
            8'h02:                      d = bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/cal_bcd_counter.sv
// Module: one BCD byte that steps from LIM_LO up to a limit given at run
// time, then wraps to LIM_LO and raises carry_out in that same cycle.
// Assumes the held value is legal BCD. A load takes priority over a step.
module cal_bcd_counter #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    LIM_LO  = '0,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         step_in,
    input  logic [W-1:0] lim_hi,
    output logic [W-1:0] cnt,
    output logic         carry_out
);
    import cal_pkg::*;

    logic at_top;

    // Find the wrap point and the carry to the next field.
    always_comb begin
        at_top    = (cnt >= lim_hi);
        carry_out = step_in && !load_en && at_top;
    end

    // Hold, load or step the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= RST_VAL;
        else if (load_en)  cnt <= load_val;
        else if (step_in)  cnt <= at_top ? LIM_LO : bcd_inc(cnt);
    end

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_in) |=> $stable(cnt));                       // R10
    AST_WRAP_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |=> (cnt == LIM_LO));                                  // R4
endmodule

// File: rtl/cal_hour_counter.sv
// Module: the hours byte. Bit 7 picks the 12-hour form, bit 5 is the PM
// flag there or the tens-of-hours bit for 20..23 in the 24-hour form.
// Raises day_carry on the step that crosses midnight. Assumes legal loads.
module cal_hour_counter #(
    parameter int           W        = 8,
    parameter logic [W-1:0] MASK     = 8'hBF,
    parameter logic [W-1:0] TOP_24   = 8'h23,
    parameter logic [W-1:0] TOP_12   = 8'h12,
    parameter logic [W-1:0] TURN_12  = 8'h11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         step_in,
    output logic [W-1:0] hr,
    output logic         day_carry
);
    import cal_pkg::*;

    logic         mode12;
    logic         pm;
    logic [W-1:0] v12;
    logic [W-1:0] v24;
    logic [W-1:0] nv;
    logic         npm;
    logic         wrap;
    logic [W-1:0] hr_next;

    // Work out the next hour value for the selected form.
    always_comb begin
        mode12 = hr[7];
        pm     = hr[5];
        v12    = {3'b000, hr[4:0]};
        v24    = {2'b00, hr[5:0]};
        nv     = '0;
        npm    = pm;
        wrap   = 1'b0;
        if (mode12) begin
            if (v12 >= TOP_12) begin
                nv = 8'h01;
            end else if (v12 == TURN_12) begin
                nv   = TOP_12;
                npm  = ~pm;
                wrap = pm;
            end else begin
                nv = bcd_inc(v12);
            end
            hr_next = {1'b1, 1'b0, npm, nv[4:0]};
        end else begin
            if (v24 >= TOP_24) begin
                nv   = '0;
                wrap = 1'b1;
            end else begin
                nv = bcd_inc(v24);
            end
            hr_next = {2'b00, nv[5:0]};
        end
        day_carry = step_in && !load_en && wrap;
    end

    // Hold, load or step the hours byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        hr <= '0;
        else if (load_en)  hr <= load_val & MASK;
        else if (step_in)  hr <= hr_next;
    end

    AST_H12_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hr[7] |-> (hr[4:0] != 5'h00 && hr[4:0] <= 5'h12));              // R6
    AST_H24_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !hr[7] |-> ({2'b00, hr[5:0]} <= TOP_24));                        // R5
    AST_MIDNIGHT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        day_carry |=> (hr[4:0] == (hr[7] ? 5'h12 : 5'h00)) && !hr[5]);   // R6
endmodule

// File: rtl/bcd_calendar_core.sv
// Module: top of the calendar core. Chains the BCD fields, holds the two
// day-byte control bits, applies the field masks on load and puts all
// eight bytes onto rd_data. Assumes tick_100hz is a one-cycle strobe.
module bcd_calendar_core
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_100hz,
    input  logic             load_en,
    input  logic [63:0]      load_data,
    output logic [63:0]      rd_data,
    output logic             rst_ignore
);
    localparam int NUM_FAST = 3;  // hundredths, seconds, minutes
    localparam logic [REG_W-1:0] FAST_TOP [NUM_FAST] = '{8'h99, 8'h59, 8'h59};

    logic [VEC_W-1:0] ld_clean;
    logic             osc_off_q;
    logic             rst_ign_q;
    logic             advance;
    logic [NUM_FAST:0]       fast_step;
    logic [REG_W-1:0]        fast_cnt [NUM_FAST];
    logic [REG_W-1:0]        hr_q;
    logic                    day_carry;
    logic [REG_W-1:0]        dow_q, date_q, month_q, year_q;
    logic                    dow_carry, date_carry, month_carry, year_carry;
    logic [REG_W-1:0]        month_len;

    // Mask the load vector and decide whether this edge counts.
    always_comb begin
        ld_clean  = load_data & FIELD_MASK;
        advance   = tick_100hz && !osc_off_q && !load_en;
        month_len = bcd_month_len(month_q, year_q);
    end

    assign fast_step[0] = advance;

    // Hundredths, seconds and minutes: the same counter with fixed tops.
    for (genvar i = 0; i < NUM_FAST; i++) begin : g_fast
        cal_bcd_counter #(.W(REG_W), .LIM_LO(8'h00), .RST_VAL(8'h00)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (load_en),
            .load_val  (ld_clean[i*REG_W +: REG_W]),
            .step_in   (fast_step[i]),
            .lim_hi    (FAST_TOP[i]),
            .cnt       (fast_cnt[i]),
            .carry_out (fast_step[i+1])
        );
    end

    cal_hour_counter #(.W(REG_W)) u_hour (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_val  (ld_clean[IDX_HOUR*REG_W +: REG_W]),
        .step_in   (fast_step[NUM_FAST]),
        .hr        (hr_q),
        .day_carry (day_carry)
    );

    cal_bcd_counter #(.W(REG_W), .LIM_LO(8'h01), .RST_VAL(8'h01)) u_dow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_val  (ld_clean[IDX_DAY*REG_W +: REG_W] & DAY_COUNT_MASK),
        .step_in   (day_carry),
        .lim_hi    (8'h07),
        .cnt       (dow_q),
        .carry_out (dow_carry)
    );

    cal_bcd_counter #(.W(REG_W), .LIM_LO(8'h01), .RST_VAL(8'h01)) u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_val  (ld_clean[IDX_DATE*REG_W +: REG_W]),
        .step_in   (day_carry),
        .lim_hi    (month_len),
        .cnt       (date_q),
        .carry_out (date_carry)
    );

    cal_bcd_counter #(.W(REG_W), .LIM_LO(8'h01), .RST_VAL(8'h01)) u_month (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_val  (ld_clean[IDX_MONTH*REG_W +: REG_W]),
        .step_in   (date_carry),
        .lim_hi    (8'h12),
        .cnt       (month_q),
        .carry_out (month_carry)
    );

    cal_bcd_counter #(.W(REG_W), .LIM_LO(8'h00), .RST_VAL(8'h00)) u_year (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_val  (ld_clean[IDX_YEAR*REG_W +: REG_W]),
        .step_in   (month_carry),
        .lim_hi    (8'h99),
        .cnt       (year_q),
        .carry_out (year_carry)
    );

    // Store the two control bits of the day byte; both reset to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_off_q <= 1'b1;
            rst_ign_q <= 1'b1;
        end else if (load_en) begin
            osc_off_q <= ld_clean[IDX_DAY*REG_W + DAY_OSC_OFF_BIT];
            rst_ign_q <= ld_clean[IDX_DAY*REG_W + DAY_RST_IGN_BIT];
        end
    end

    // Assemble the read vector in byte order.
    always_comb begin
        rd_data = {year_q, month_q, date_q,
                   {2'b00, osc_off_q, rst_ign_q, 1'b0, dow_q[2:0]},
                   hr_q, fast_cnt[2], fast_cnt[1], fast_cnt[0]};
        rst_ignore = rst_ign_q;
    end

    AST_LOAD_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (rd_data == $past(load_data & FIELD_MASK)));          // R2
    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~FIELD_MASK) == '0);                                  // R2
    AST_OSC_OFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && osc_off_q) |=> $stable(rd_data));                    // R10
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        dow_carry |=> (dow_q == 8'h01));                                  // R7
    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        year_carry |=> (year_q == 8'h00));                                // R9
endmodule

// File: tb/tb_bcd_calendar_core.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected read vectors and tags into
// queues, and a monitor at each falling edge pops them and compares.
module tb_bcd_calendar_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_100hz = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_data = '0;
    logic [63:0] rd_data;
    logic        rst_ignore;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    bcd_calendar_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_100hz (tick_100hz),
        .load_en    (load_en),
        .load_data  (load_data),
        .rd_data    (rd_data),
        .rst_ignore (rst_ignore)
    );

    // Drive one cycle of inputs; queue an expectation when a tag is given.
    task automatic step(input logic ld, input logic [63:0] d, input logic tk,
                        input logic [63:0] exp_v, input string tag);
        @(negedge clk);
        load_en    = ld;
        load_data  = d;
        tick_100hz = tk;
        @(posedge clk);
        #1;
        if (tag != "") begin
            exp_q.push_back(exp_v);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle();
        step(1'b0, 64'h0, 1'b0, 64'h0, "");
    endtask

    // Load v, then one tick, expecting e.
    task automatic roll(input logic [63:0] v, input logic [63:0] e, input string tag);
        step(1'b1, v, 1'b0, 64'h0, "");
        step(1'b0, 64'h0, 1'b1, e, tag);
    endtask

    // Monitor: compare the read vector and rst_ignore (day bit 4, R11).
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                fails++;
                $display("FAIL %s rd_data actual=%h expected=%h", t, rd_data, e);
            end
            checks++;
            if (rst_ignore !== e[36]) begin
                fails++;
                $display("FAIL R11 (%s) rst_ignore actual=%b expected=%b", t, rst_ignore, e[36]);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle();
        // R1: reset state, oscillator off so counting is stopped (R10)
        step(1'b0, 64'h0, 1'b0, 64'h00_01_01_31_00_00_00_00, "R1");
        step(1'b0, 64'h0, 1'b1, 64'h00_01_01_31_00_00_00_00, "R10 tick while reset-off");
        // R2: junk in unused bits is dropped
        step(1'b1, 64'h99_F2_F1_C7_63_D9_D9_99, 1'b0, 64'h99_12_31_07_23_59_59_99, "R2");
        // R4 R5 R7 R9: full roll-over of every field
        step(1'b0, 64'h0, 1'b1, 64'h00_01_01_01_00_00_00_00, "R4 R5 R7 R9");
        // R3: tick with load is dropped; then a BCD digit carry
        step(1'b1, 64'h24_02_28_03_10_30_15_09, 1'b1, 64'h24_02_28_03_10_30_15_09, "R3 load wins");
        step(1'b0, 64'h0, 1'b1, 64'h24_02_28_03_10_30_15_10, "R3 09->10");
        idle();
        step(1'b0, 64'h0, 1'b0, 64'h24_02_28_03_10_30_15_10, "R3 no tick holds");
        // R4 R5: 24-hour 09:59:59.99 -> 10:00
        roll(64'h23_07_04_02_09_59_59_99, 64'h23_07_04_02_10_00_00_00, "R4 R5");
        // R8: month lengths
        roll(64'h24_02_28_03_23_59_59_99, 64'h24_02_29_04_00_00_00_00, "R8 leap 28->29");
        roll(64'h24_02_29_04_23_59_59_99, 64'h24_03_01_05_00_00_00_00, "R8 leap 29->01");
        roll(64'h23_02_28_02_23_59_59_99, 64'h23_03_01_03_00_00_00_00, "R8 common 28->01");
        roll(64'h00_02_28_01_23_59_59_99, 64'h00_02_29_02_00_00_00_00, "R8 year 00 leap");
        roll(64'h23_04_30_06_23_59_59_99, 64'h23_05_01_07_00_00_00_00, "R8 30-day month");
        roll(64'h23_01_30_02_23_59_59_99, 64'h23_01_31_03_00_00_00_00, "R8 31-day month");
        // R7: day 7 wraps to 1
        roll(64'h23_01_31_07_23_59_59_99, 64'h23_02_01_01_00_00_00_00, "R7");
        // R9: December 31 -> January 01 and year step
        roll(64'h41_12_31_05_23_59_59_99, 64'h42_01_01_06_00_00_00_00, "R9");
        // R6: 12-hour sequence
        roll(64'h23_06_15_02_91_59_59_99, 64'h23_06_15_02_B2_00_00_00, "R6 AM11->PM12");
        roll(64'h23_06_15_02_B2_59_59_99, 64'h23_06_15_02_A1_00_00_00, "R6 PM12->PM1");
        roll(64'h23_06_15_02_92_59_59_99, 64'h23_06_15_02_81_00_00_00, "R6 AM12->AM1");
        roll(64'h23_06_15_02_B1_59_59_99, 64'h23_06_16_03_92_00_00_00, "R6 PM11->AM12 date");
        // R10: oscillator off holds every byte across ticks
        step(1'b1, 64'h23_06_15_22_10_20_30_40, 1'b0, 64'h23_06_15_22_10_20_30_40, "R10 load");
        step(1'b0, 64'h0, 1'b1, 64'h0, "");
        step(1'b0, 64'h0, 1'b1, 64'h23_06_15_22_10_20_30_40, "R10 frozen");
        // R11: reset-ignore set, oscillator on: counts and drives rst_ignore
        roll(64'h23_06_15_12_10_20_30_40, 64'h23_06_15_12_10_20_30_41, "R11");
        idle();
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule